// File: doc/BRIEF.md
# Byte-Window I2C Target with Auto-Incrementing Pointer

This block is an I2C target that gives an external bus controller access to a window of 256 byte locations held in an on-chip register array. It acknowledges its address byte when the 7-bit address matches either a value set on the `slave_addr` pins or the fixed alert-response address 7'h0C. Both addresses open the same window. A write transaction carries a pointer byte first. Every following byte is stored at the pointer, and the pointer then advances by one. A read transaction returns the byte at the pointer and advances it the same way. The pointer wraps from 255 to 0, and a transaction has no length limit.

The controller can change direction by issuing a repeated Start instead of a Stop. A read after a repeated Start, or after a Stop, continues from wherever the pointer was left. SCL and SDA are oversampled in the block clock domain through two synchronizer flops. Start and Stop are recognised as SDA edges while SCL is high. The block drives SDA only as an open-drain pull-down through `sda_oe`.

The bus has no back-pressure. The target never stretches SCL. Each byte it returns is fetched from the array before the first falling SCL edge of that byte, so the block clock must run several times faster than SCL.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset `sda_oe` is 0, the pointer is 0 and every array location reads as 0x00.
- R2: The address byte (7-bit address in bits 7:1, bit 0 = 1 for read) is acknowledged only when its address equals `slave_addr` or 7'h0C. On a mismatch, no later byte is acknowledged or stored until the next Start.
- R3: In a write transaction the first byte after the address loads the pointer and is acknowledged.
- R4: Each further written byte is acknowledged and stored at the pointer, and the pointer then increments, wrapping from 255 to 0.
- R5: A read returns the byte at the pointer, MSB first, and increments the pointer after each byte, wrapping from 255 to 0.
- R6: A read continues for as long as the controller acknowledges. After a NACK from the controller, the target leaves SDA released.
- R7: The target changes its SDA drive only while SCL is low.
- R8: A repeated Start begins a new transaction without a Stop. The pointer is kept across repeated Starts and Stops, so a read without a pointer byte continues from the last position.
- R9: The alert-response address 7'h0C gives the same read and write access to the window as `slave_addr`.
- R10: A single write or read burst longer than 256 bytes wraps around the window. The last byte written to a location is the one read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| slave_addr | input | 7 | Programmable 7-bit target address |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions check several rules on every cycle:
- SDA drive changes only while the synchronized SCL is low.
- An address acknowledge is entered only after an address match.
- Every array write happens after a pointer byte and leaves the pointer one past the written location.
- SDA stays released once the controller has refused a byte.

Only the bench scenarios can show the end-to-end effects. These are that the stored bytes are the ones read back, that the window wraps at 255, that a mismatched address leaves the array untouched, that the pointer survives repeated Starts and Stops, and that a burst longer than the window returns the last data written.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam logic [6:0] ALERT_ADDR = 7'h0C;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_WRX, S_WACK, S_RD, S_RACK, S_RWAIT
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/reg_window_mem.sv
module reg_window_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/i2c_slave_ctrl.sv
module i2c_slave_ctrl
  import i2c_reg_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    slave_addr,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic          sda_oe
);
  slv_state_e state;
  logic [3:0] bitcnt;
  logic [BYTE_W-1:0] rx, tx;
  logic rd_mode, got_ptr, mack;
  logic hit;

  assign hit = (rx[7:1] == slave_addr) || (rx[7:1] == ALERT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; rx <= '0; tx <= '0;
      rd_mode <= 1'b0; got_ptr <= 1'b0; mack <= 1'b0;
      ptr <= '0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      sda_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WRX: begin
            if (scl_rise) begin
              rx <= {rx[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (state == S_ADDR) begin
                if (hit) begin
                  state <= S_AACK; sda_oe <= 1'b1; rd_mode <= rx[0];
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                state <= S_WACK; sda_oe <= 1'b1;
                if (!got_ptr) begin
                  ptr <= rx[AW-1:0]; got_ptr <= 1'b1;
                end else begin
                  wr_en <= 1'b1; wr_addr <= ptr; wr_data <= rx;
                  ptr <= ptr + AW'(1);
                end
              end
            end
          end
          S_AACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode) begin
              state <= S_RD; tx <= rd_data; sda_oe <= ~rd_data[7];
            end else begin
              state <= S_WRX; sda_oe <= 1'b0; got_ptr <= 1'b0;
            end
          end
          S_WACK: if (scl_fall) begin
            state <= S_WRX; sda_oe <= 1'b0; bitcnt <= '0;
          end
          S_RD: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              state <= S_RACK; sda_oe <= 1'b0; ptr <= ptr + AW'(1);
            end else begin
              bitcnt <= bitcnt + 4'd1;
              tx <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                state <= S_RD; bitcnt <= '0;
                tx <= rd_data; sda_oe <= ~rd_data[7];
              end else begin
                state <= S_RWAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r7_drive_changes_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));
  a_r2_ack_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_AACK && $past(state) == S_ADDR) |->
      ($past(rx[7:1]) == slave_addr || $past(rx[7:1]) == ALERT_ADDR));
  a_r4_ptr_past_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == wr_addr + AW'(1)));
  a_r3_write_after_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> got_ptr);
  a_r6_released_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RWAIT) |-> !sda_oe);
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] slave_addr,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] ptr, wr_addr;
  logic wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .slave_addr(slave_addr),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
    .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_oe(sda_oe)
  );

  reg_window_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data)
  );
endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [6:0] slave_addr = 7'h52;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  i2c_reg_slave i_i2c_reg_slave (
    .clk(clk), .rst_n(rst_n), .slave_addr(slave_addr),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  int n_cmp = 0, n_bad = 0, r7_viol = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] bptr = 8'h00;
  logic [7:0] exp_q [$];
  logic [7:0] obs_q [$];
  string      tag_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge clk);
    if (obs_q.size() > 0 && exp_q.size() > 0) begin
      automatic logic [7:0] o = obs_q.pop_front();
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(o === e, t, int'(o), int'(e));
    end
  end

  // R7: SDA drive may change only while SCL is low
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) r7_viol++;
    oe_prev <= sda_oe;
  end

  task automatic qw; repeat (5) @(posedge clk); #1; endtask
  task automatic bus_start;
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask
  task automatic put_bit(input logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask
  task automatic get_bit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_line; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic send_byte(input logic [7:0] d, input bit exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    check((!a) == exp_ack, {tag, " ack"}, int'(!a), int'(exp_ack));
  endtask
  task automatic recv_byte(input bit last, input string tag);
    logic [7:0] d;
    logic b;
    exp_q.push_back(model[bptr]); tag_q.push_back(tag);
    bptr = bptr + 8'd1;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    obs_q.push_back(d);
    put_bit(last);
  endtask
  task automatic do_write(input logic [6:0] a, input logic [7:0] p,
                          input logic [7:0] data [$], input bit stop, input string tag);
    bus_start();
    send_byte({a, 1'b0}, 1'b1, {tag, " addr"});
    send_byte(p, 1'b1, {tag, " ptr"});
    bptr = p;
    foreach (data[i]) begin
      send_byte(data[i], 1'b1, {tag, " data"});
      model[bptr] = data[i];
      bptr = bptr + 8'd1;
    end
    if (stop) bus_stop();
  endtask
  task automatic do_read(input logic [6:0] a, input int n, input string tag);
    bus_start();
    send_byte({a, 1'b1}, 1'b1, {tag, " addr"});
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, tag);
    qw();
    check(sda_oe == 1'b0, "R6 released after NACK", int'(sda_oe), 0);
    bus_stop();
  endtask

  initial begin
    logic [7:0] none [$];
    logic [7:0] burst [$];
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (4) @(posedge clk); #1;
    check(sda_oe == 1'b0, "R1 reset sda_oe", int'(sda_oe), 0);
    rst_n = 1'b1; qw();

    do_read(7'h52, 2, "R1 reset contents");
    do_write(7'h52, 8'h10, '{8'hA1, 8'hB2, 8'hC3}, 1'b1, "R4 write");
    do_write(7'h52, 8'h10, none, 1'b0, "R3 ptr load");
    do_read(7'h52, 3, "R8 restart read R5");
    do_write(7'h52, 8'hFE, '{8'h11, 8'h22, 8'h33}, 1'b1, "R4 wrap write");
    do_write(7'h52, 8'hFE, none, 1'b0, "R3 ptr FE");
    do_read(7'h52, 3, "R5 wrap read");

    // R2: mismatched address is ignored
    bus_start();
    send_byte({7'h33, 1'b0}, 1'b0, "R2 mismatch addr");
    send_byte(8'h10, 1'b0, "R2 mismatch ptr");
    send_byte(8'hEE, 1'b0, "R2 mismatch data");
    bus_stop();
    do_write(7'h52, 8'h10, none, 1'b0, "R2 ptr");
    do_read(7'h52, 1, "R2 unchanged");

    do_write(7'h0C, 8'h20, '{8'h5A, 8'h6B}, 1'b1, "R9 alert write");
    do_write(7'h52, 8'h20, none, 1'b0, "R9 ptr");
    do_read(7'h0C, 1, "R9 alert read");
    do_read(7'h52, 1, "R8 continue after stop");

    slave_addr = 7'h2D;
    do_write(7'h2D, 8'h80, '{8'h99}, 1'b1, "R2 new addr write");
    bus_start();
    send_byte({7'h52, 1'b1}, 1'b0, "R2 old addr nack");
    bus_stop();

    for (int i = 0; i < 260; i++) burst.push_back(8'(i * 7 + 3));
    do_write(7'h2D, 8'h40, burst, 1'b1, "R10 long write");
    do_write(7'h2D, 8'h40, none, 1'b0, "R10 ptr");
    do_read(7'h2D, 260, "R10 long read");

    repeat (10) @(posedge clk); #1;
    check(r7_viol == 0, "R7 drive change with SCL high", r7_viol, 0);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule